// File: doc/BRIEF.md
# Pattern Buffer Indirect Write Port

This block fills a test-pattern buffer through a small set of 32-bit registers instead of a direct memory-mapped store. The buffer has 64 lines, and each line holds 8 chunks of 64 bits. Software loads a 64-bit word in two 32-bit halves and sets an access-control register. That register picks the target chunk and turns on access mode. A write to the command register then carries a line address and an opcode. When the opcode means "write" and the access settings are valid, the staged word is stored in the chosen chunk of the chosen line.

Access mode is a separate gate. The control register must hold the access mode value, select the pattern buffer as its target array, and have the replicate flag clear. When any of these is not true, command writes do nothing. Software leaves access mode by writing zero to the control register. The staged halves keep their values between commits, so one word can go into several chunks without being loaded again. A combinational debug port reads back any (line, chunk) entry for checking.

The register bus is a plain single-cycle write strobe with no back-pressure. The block accepts one register write in every cycle that `reg_wr_en` is high.

Top module: `pbuf_indirect_port`

## Requirements
- R1: After reset, every buffer entry reads zero on the debug port, and the staged word and the access-control register are zero.
- R2: A write to register index 0 sets bits 31:0 of the staged word, and a write to index 1 sets bits 63:32. A commit stores the word {index1, index0}.
- R3: The command register is index 3. A commit happens when the command write has opcode 4'b1000 in bits 27:24 and the access-control register (index 2) holds mode 1 in bits 17:16, array select 0 in bits 9:5, and replicate bit 11 clear. The commit writes only the chunk named in control bits 3:0 of the line named in command bits 11:0. All other entries are unchanged.
- R4: The committed word appears on the debug port at the clock edge that takes the command write. There is no extra latency.
- R5: A command write with any opcode other than 4'b1000 leaves the buffer unchanged.
- R6: When the access-control register has a mode other than 1, a nonzero array select, or the replicate bit set, a command write leaves the buffer unchanged. Writing zero to the control register therefore ends access mode.
- R7: A command line address of 64 or more (bits 11:0) leaves the buffer unchanged.
- R8: A chunk select of 8 or more (control bits 3:0) leaves the buffer unchanged.
- R9: The staged word keeps its value until index 0 or index 1 is written again, so repeated commits store the same word.
- R10: Writes to indices 0, 1 and 2 never change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe for this cycle |
| reg_wr_idx | input | 2 | Register index: 0 data low, 1 data high, 2 access control, 3 command |
| reg_wr_data | input | 32 | Register write value |
| dbg_line | input | 6 | Debug read line |
| dbg_chunk | input | 3 | Debug read chunk |
| dbg_data | output | 64 | Debug read data for (dbg_line, dbg_chunk), combinational |

## Verification
A wrong gate in the decode is the most visible kind of fault. The debug port shows it right after the command edge: a word lands where none should, or an expected word is missing. A corrupted staged word or control value stays hidden until the next commit, so the bench checks the addressed entry after every random command and also checks the neighbouring chunks and lines of the directed commits. A final sweep of all 512 entries catches stray writes to entries that were never looked at during the run.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int REG_W       = 32;
  localparam int WORD_W      = 2 * REG_W;
  localparam int CMD_ADDR_W  = 12;
  localparam int CMD_OP_LSB  = 24;
  localparam int CMD_OP_W    = 4;
  localparam logic [CMD_OP_W-1:0] OP_WRITE = 4'b1000;
  localparam int CTL_CHUNK_W   = 4;
  localparam int CTL_ARRAY_LSB = 5;
  localparam int CTL_ARRAY_W   = 5;
  localparam int CTL_REP_BIT   = 11;
  localparam int CTL_MODE_LSB  = 16;
  localparam int CTL_MODE_W    = 2;
  localparam logic [CTL_MODE_W-1:0] MODE_ACCESS = 2'd1;

  typedef enum logic [1:0] {
    IDX_DATA_LO = 2'd0,
    IDX_DATA_HI = 2'd1,
    IDX_ACC_CTL = 2'd2,
    IDX_CMD     = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/pbuf_stage_regs.sv
module pbuf_stage_regs
  import pbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  output logic [WORD_W-1:0] stage_data,
  output logic [REG_W-1:0]  acc_ctl
);
  logic [REG_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      acc_ctl <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_DATA_LO: lo_q    <= wr_data;
        IDX_DATA_HI: hi_q    <= wr_data;
        IDX_ACC_CTL: acc_ctl <= wr_data;
        default: ;
      endcase
    end
  end

  assign stage_data = {hi_q, lo_q};
endmodule

// File: rtl/pbuf_commit_decode.sv
module pbuf_commit_decode
  import pbuf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  localparam int LINE_AW = $clog2(LINES)
) (
  input  logic               wr_en,
  input  reg_idx_e           wr_idx,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W-1:0]   acc_ctl,
  output logic [LINE_AW-1:0] commit_line,
  output logic [CHUNKS-1:0]  chunk_we
);
  logic [CMD_ADDR_W-1:0]  cmd_addr;
  logic [CMD_OP_W-1:0]    cmd_op;
  logic [CTL_CHUNK_W-1:0] chunk_sel;
  logic [CTL_ARRAY_W-1:0] array_sel;
  logic [CTL_MODE_W-1:0]  mode_sel;
  logic rep_flag, cmd_hit, line_ok, chunk_ok, mode_ok, go;
  logic unused_fields;

  assign cmd_addr  = wr_data[CMD_ADDR_W-1:0];
  assign cmd_op    = wr_data[CMD_OP_LSB +: CMD_OP_W];
  assign chunk_sel = acc_ctl[CTL_CHUNK_W-1:0];
  assign array_sel = acc_ctl[CTL_ARRAY_LSB +: CTL_ARRAY_W];
  assign rep_flag  = acc_ctl[CTL_REP_BIT];
  assign mode_sel  = acc_ctl[CTL_MODE_LSB +: CTL_MODE_W];

  assign unused_fields = ^{wr_data[CMD_OP_LSB-1:CMD_ADDR_W], wr_data[REG_W-1:CMD_OP_LSB+CMD_OP_W],
                           acc_ctl[CTL_ARRAY_LSB-1:CTL_CHUNK_W], acc_ctl[CTL_REP_BIT-1:CTL_ARRAY_LSB+CTL_ARRAY_W],
                           acc_ctl[CTL_MODE_LSB-1:CTL_REP_BIT+1], acc_ctl[REG_W-1:CTL_MODE_LSB+CTL_MODE_W]};

  assign cmd_hit  = wr_en && (wr_idx == IDX_CMD) && (cmd_op == OP_WRITE);
  assign line_ok  = cmd_addr < CMD_ADDR_W'(LINES);
  assign chunk_ok = chunk_sel < CTL_CHUNK_W'(CHUNKS);
  assign mode_ok  = (mode_sel == MODE_ACCESS) && (array_sel == '0) && !rep_flag;
  assign go       = cmd_hit && line_ok && chunk_ok && mode_ok;

  assign commit_line = cmd_addr[LINE_AW-1:0];

  for (genvar c = 0; c < CHUNKS; c++) begin : g_we
    assign chunk_we[c] = go && (chunk_sel == CTL_CHUNK_W'(c));
  end
endmodule

// File: rtl/pbuf_line_store.sv
module pbuf_line_store #(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  parameter int WORD_W = 64,
  localparam int LINE_AW  = $clog2(LINES),
  localparam int CHUNK_AW = $clog2(CHUNKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_AW-1:0]  wr_line,
  input  logic [CHUNKS-1:0]   wr_chunk_we,
  input  logic [WORD_W-1:0]   wr_word,
  input  logic [LINE_AW-1:0]  rd_line,
  input  logic [CHUNK_AW-1:0] rd_chunk,
  output logic [WORD_W-1:0]   rd_word
);
  logic [WORD_W-1:0] bank_rd [CHUNKS];

  for (genvar c = 0; c < CHUNKS; c++) begin : g_bank
    logic [WORD_W-1:0] bank [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < LINES; i++) bank[i] <= '0;
      end else if (wr_chunk_we[c]) begin
        bank[wr_line] <= wr_word;
      end
    end

    assign bank_rd[c] = bank[rd_line];
  end

  assign rd_word = bank_rd[rd_chunk];
endmodule

// File: rtl/pbuf_indirect_port.sv
module pbuf_indirect_port
  import pbuf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  localparam int LINE_AW  = $clog2(LINES),
  localparam int CHUNK_AW = $clog2(CHUNKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_wr_idx,
  input  logic [REG_W-1:0]    reg_wr_data,
  input  logic [LINE_AW-1:0]  dbg_line,
  input  logic [CHUNK_AW-1:0] dbg_chunk,
  output logic [WORD_W-1:0]   dbg_data
);
  reg_idx_e            idx;
  logic [WORD_W-1:0]   stage_data;
  logic [REG_W-1:0]    acc_ctl;
  logic [LINE_AW-1:0]  commit_line;
  logic [CHUNKS-1:0]   chunk_we;

  assign idx = reg_idx_e'(reg_wr_idx);

  pbuf_stage_regs u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_idx     (idx),
    .wr_data    (reg_wr_data),
    .stage_data (stage_data),
    .acc_ctl    (acc_ctl)
  );

  pbuf_commit_decode #(.LINES(LINES), .CHUNKS(CHUNKS)) u_decode (
    .wr_en       (reg_wr_en),
    .wr_idx      (idx),
    .wr_data     (reg_wr_data),
    .acc_ctl     (acc_ctl),
    .commit_line (commit_line),
    .chunk_we    (chunk_we)
  );

  pbuf_line_store #(.LINES(LINES), .CHUNKS(CHUNKS), .WORD_W(WORD_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_line     (commit_line),
    .wr_chunk_we (chunk_we),
    .wr_word     (stage_data),
    .rd_line     (dbg_line),
    .rd_chunk    (dbg_chunk),
    .rd_word     (dbg_data)
  );
endmodule

// File: rtl/pbuf_port_checker.sv
module pbuf_port_checker
  import pbuf_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CHUNKS = 8,
  localparam int LINE_AW  = $clog2(LINES),
  localparam int CHUNK_AW = $clog2(CHUNKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic [1:0]          reg_wr_idx,
  input logic [REG_W-1:0]    reg_wr_data,
  input logic [LINE_AW-1:0]  dbg_line,
  input logic [CHUNK_AW-1:0] dbg_chunk,
  input logic [WORD_W-1:0]   dbg_data,
  input logic [WORD_W-1:0]   stage_data,
  input logic [REG_W-1:0]    acc_ctl,
  input logic [LINE_AW-1:0]  commit_line,
  input logic [CHUNKS-1:0]   chunk_we
);
  logic cmd_wr;
  assign cmd_wr = reg_wr_en && (reg_wr_idx == 2'd3);

  a_r10_commit_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_we != '0) |-> cmd_wr);

  a_r3_one_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chunk_we));

  a_r6_access_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_we != '0) |-> (acc_ctl[17:16] == 2'd1 && acc_ctl[9:5] == 5'd0 && !acc_ctl[11]));

  a_r5_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wr_data[27:24] != 4'b1000) |-> (chunk_we == '0));

  a_r7_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wr_data[11:0] >= 12'(LINES)) |-> (chunk_we == '0));

  a_r9_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_wr_idx[1] == 1'b0) |=> $stable(stage_data));

  a_r4_commit_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_we[dbg_chunk] && commit_line == dbg_line) |=>
      (dbg_data == $past(stage_data) || !$stable(dbg_line) || !$stable(dbg_chunk)));
endmodule

bind pbuf_indirect_port pbuf_port_checker #(.LINES(LINES), .CHUNKS(CHUNKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_idx  (reg_wr_idx),
  .reg_wr_data (reg_wr_data),
  .dbg_line    (dbg_line),
  .dbg_chunk   (dbg_chunk),
  .dbg_data    (dbg_data),
  .stage_data  (stage_data),
  .acc_ctl     (acc_ctl),
  .commit_line (commit_line),
  .chunk_we    (chunk_we)
);

// File: tb/pbuf_indirect_port_tb_top.sv
`timescale 1ns/1ps
module pbuf_indirect_port_tb_top;
  localparam int NL = 64;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic [5:0]  dbg_line = '0;
  logic [2:0]  dbg_chunk = '0;
  logic [63:0] dbg_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] exp_mem [NL][NC];
  logic [31:0] m_lo = '0, m_hi = '0, m_ctl = '0;

  always #4 clk = ~clk;

  pbuf_indirect_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .dbg_line(dbg_line), .dbg_chunk(dbg_chunk), .dbg_data(dbg_data)
  );

  function automatic bit commit_ok(input logic [31:0] ctl, input logic [31:0] cmd);
    return (cmd[27:24] == 4'b1000) && (ctl[17:16] == 2'd1) && (ctl[9:5] == 5'd0) &&
           !ctl[11] && (cmd[11:0] < 12'd64) && (ctl[3:0] < 4'd8);
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (idx)
      2'd0: m_lo = d;
      2'd1: m_hi = d;
      2'd2: m_ctl = d;
      default: if (commit_ok(m_ctl, d)) exp_mem[d[5:0]][m_ctl[2:0]] = {m_hi, m_lo};
    endcase
  endtask

  task automatic chk_val(input string tag, input int line, input int chunk, input logic [63:0] expv);
    dbg_line = line[5:0]; dbg_chunk = chunk[2:0];
    #1;
    total++;
    if (dbg_data !== expv) begin
      bad++;
      $display("FAIL %s line=%0d chunk=%0d actual=%h expected=%h", tag, line, chunk, dbg_data, expv);
    end
  endtask

  task automatic chk(input string tag, input int line, input int chunk);
    chk_val(tag, line, chunk, exp_mem[line][chunk]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) exp_mem[l][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared after reset
    chk_val("R1", 0, 0, 64'h0);
    chk_val("R1", 63, 7, 64'h0);
    chk_val("R1", 5, 3, 64'h0);

    // R2 / R10: staging alone does not touch the buffer
    wr(2'd0, 32'h89ab_cdef);
    wr(2'd1, 32'h0123_4567);
    wr(2'd2, 32'h0001_0003);
    chk_val("R10", 5, 3, 64'h0);
    wr(2'd3, 32'h0800_0005);
    chk_val("R2", 5, 3, 64'h0123_4567_89ab_cdef);
    // R4: visible right after the command edge (sampled one half cycle later)
    chk("R4", 5, 3);
    // R3: neighbours untouched
    chk_val("R3", 5, 2, 64'h0);
    chk_val("R3", 5, 4, 64'h0);
    chk_val("R3", 4, 3, 64'h0);

    // R9: reuse staged word on another chunk
    wr(2'd2, 32'h0001_0006);
    wr(2'd3, 32'h0800_0005);
    chk_val("R9", 5, 6, 64'h0123_4567_89ab_cdef);

    // R5: wrong opcodes
    wr(2'd0, 32'h5555_aaaa);
    wr(2'd3, 32'h0400_0007);
    chk_val("R5", 7, 6, 64'h0);
    wr(2'd3, 32'h0900_0007);
    chk_val("R5", 7, 6, 64'h0);

    // R7: out of range line
    wr(2'd3, 32'h0800_0040);
    chk_val("R7", 0, 6, 64'h0);
    wr(2'd3, 32'h0800_0fff);
    chk_val("R7", 63, 6, 64'h0);

    // R8: out of range chunk
    wr(2'd2, 32'h0001_0009);
    wr(2'd3, 32'h0800_0001);
    chk_val("R8", 1, 1, 64'h0);

    // R6: mode leave, array, replicate, other mode
    wr(2'd2, 32'h0000_0000);
    wr(2'd3, 32'h0800_0002);
    chk_val("R6", 2, 0, 64'h0);
    wr(2'd2, 32'h0001_0020);
    wr(2'd3, 32'h0800_0002);
    chk_val("R6", 2, 0, 64'h0);
    wr(2'd2, 32'h0001_0800);
    wr(2'd3, 32'h0800_0002);
    chk_val("R6", 2, 0, 64'h0);
    wr(2'd2, 32'h0002_0000);
    wr(2'd3, 32'h0800_0002);
    chk_val("R6", 2, 0, 64'h0);
    wr(2'd2, 32'h0001_0000);
    wr(2'd3, 32'h0800_0002);
    chk_val("R9", 2, 0, 64'h0123_4567_5555_aaaa);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [31:0] d;
      k = $urandom_range(0, 3);
      d = $urandom;
      if (k == 2) begin
        d[3:0]   = ($urandom_range(0, 9) < 9) ? 4'($urandom_range(0, 7)) : 4'($urandom_range(8, 15));
        d[17:16] = ($urandom_range(0, 99) < 85) ? 2'd1 : 2'($urandom_range(0, 3));
        d[9:5]   = ($urandom_range(0, 99) < 90) ? 5'd0 : 5'($urandom_range(1, 31));
        d[11]    = ($urandom_range(0, 99) < 90) ? 1'b0 : 1'b1;
      end else if (k == 3) begin
        d[27:24] = ($urandom_range(0, 99) < 85) ? 4'b1000 : 4'($urandom_range(0, 15));
        d[11:0]  = ($urandom_range(0, 99) < 90) ? 12'($urandom_range(0, 63)) : 12'($urandom_range(64, 4095));
      end
      wr(2'(k), d);
      if (k == 3) chk("R3", int'(d[5:0]), int'(m_ctl[2:0]));
      else chk("R10", int'($urandom_range(0, 63)), int'($urandom_range(0, 7)));
    end

    // Full sweep
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) chk("R3", l, c);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule